// File: doc/BRIEF.md
# Shift-then-saturate arithmetic unit

This unit clamps a 32-bit two's-complement operand into a range whose width is chosen per operation. It can clamp to a signed range or to an unsigned range. In scalar mode the operand first passes through a barrel shifter, which does a logical left shift or an arithmetic right shift by an immediate amount. The shifted word is then clamped as a single value. In dual mode the shifter is bypassed. Each 16-bit half of the operand is sign-extended, clamped on its own, and written back into the same half of the result.

Every result that had to be clipped raises a one-cycle `q_set` pulse beside the result. The surrounding pipeline ORs this pulse into its own sticky overflow flag, which sits at bit 27 of its condition word. When nothing was clipped, the pulse stays low and that flag keeps its value. The whole datapath is combinational and ends in one register stage, so results appear exactly one clock after an operation is presented.

Top module: `sat_shift_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `out_valid`, `q_set` and `result` are all zero.
- R2: An operation presented with `in_valid` high appears on `result`, `out_valid` and `q_set` on the following clock edge. A cycle with `in_valid` low gives `out_valid`=0 and `q_set`=0 on the next edge and leaves `result` unchanged.
- R3: Scalar signed mode (`is_dual`=0, `is_unsigned`=0): with N = `sat_imm`+1 (1..32), the shifted value is clamped to the range -2^(N-1) to 2^(N-1)-1.
- R4: Scalar unsigned mode (`is_unsigned`=1): with N = `sat_imm` (0..31), the shifted value is clamped to the range 0 to 2^N-1. Negative values become 0, so bit 31 of the result is always 0.
- R5: When `shift_kind`=0, the operand is shifted left logically by `shift_amt` (0..31) before the clamp. Bits shifted out are lost.
- R6: When `shift_kind`=1, the operand is shifted right arithmetically by `shift_amt`. An amount of 0 means a shift of 32, which gives all copies of the sign bit.
- R7: Dual mode (`is_dual`=1): bits 15:0 and bits 31:16 are each sign-extended and clamped with the same signed or unsigned N as in R3 or R4. Each clamped value goes into its own half of the result. `shift_amt` and `shift_kind` have no effect.
- R8: `q_set` is 1 in the output cycle of an operation exactly when the scalar value was clipped or, in dual mode, when either half was clipped. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| operand | input | 32 | Value to shift and clamp |
| shift_amt | input | 5 | Immediate shift amount |
| shift_kind | input | 1 | 0 = logical left, 1 = arithmetic right |
| sat_imm | input | 5 | Saturation width code (N-1 when signed, N when unsigned) |
| is_unsigned | input | 1 | 1 selects the unsigned clamp range |
| is_dual | input | 1 | 1 selects two independent halfword clamps |
| out_valid | output | 1 | A result is on `result` this cycle |
| result | output | 32 | Clamped result |
| q_set | output | 1 | Pulse: the result was clipped |

## Verification
The bench targets the following corner cases and the wrong output each one would expose:
- An arithmetic right shift coded as 0. A design that treats it as no shift returns the operand instead of the spread sign.
- The signed width of 32 and the unsigned width of 0. An off-by-one in the limit either clips every value or clips nothing.
- Negative operands under the unsigned clamp. A design that compares without sign would pass them through as huge positive values.
- Dual mode with one half clipping and the other not, under a non-zero shift. This catches halves that are clamped together, flags taken from only one half, and a shifter left in the dual path.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int WORD_W = 32;

    typedef enum logic {
        SH_LSL = 1'b0,
        SH_ASR = 1'b1
    } shift_kind_e;

endpackage

// File: rtl/sat_barrel.sv
module sat_barrel #(
    parameter int DW = 32,
    parameter int SW = 5
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    input  logic          kind,
    output logic [DW-1:0] dout
);
    import sat_pkg::*;

    always_comb begin
        if (kind == SH_ASR) begin
            // a zero amount encodes the full-width shift
            if (amt == '0) dout = {DW{din[DW-1]}};
            else           dout = DW'($signed(din) >>> amt);
        end else begin
            dout = din << amt;
        end
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int DW = 32,
    parameter int SW = 5
) (
    input  logic [DW-1:0] val,
    input  logic [SW-1:0] imm,
    input  logic          uns,
    output logic [DW-1:0] res,
    output logic          clip
);
    logic signed [DW:0] v_x;
    logic signed [DW:0] lim;
    logic signed [DW:0] hi;
    logic signed [DW:0] lo;

    always_comb begin
        v_x = {val[DW-1], val};
        lim = {{DW{1'b0}}, 1'b1} << imm;
        // signed: 2^(N-1) with N=imm+1; unsigned: 2^N with N=imm
        hi  = lim - 1;
        lo  = uns ? '0 : -lim;
        if (v_x > hi) begin
            res  = hi[DW-1:0];
            clip = 1'b1;
        end else if (v_x < lo) begin
            res  = lo[DW-1:0];
            clip = 1'b1;
        end else begin
            res  = val;
            clip = 1'b0;
        end
    end

endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit #(
    parameter int DATA_W = sat_pkg::WORD_W,
    localparam int HALF_W = DATA_W / 2,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic              shift_kind,
    input  logic [SH_W-1:0]   sat_imm,
    input  logic              is_unsigned,
    input  logic              is_dual,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              q_set
);

    typedef struct packed {
        logic              valid;
        logic              qset;
        logic              uns;
        logic              dual;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] scal_res;
    logic              scal_clip;
    logic [DATA_W-1:0] lane_res [LANES];
    logic [LANES-1:0]  lane_clip;
    logic [DATA_W-1:0] dual_word;

    sat_barrel #(.DW(DATA_W), .SW(SH_W)) u_shift (
        .din (operand),
        .amt (shift_amt),
        .kind(shift_kind),
        .dout(shifted)
    );

    sat_clamp #(.DW(DATA_W), .SW(SH_W)) u_scal (
        .val (shifted),
        .imm (sat_imm),
        .uns (is_unsigned),
        .res (scal_res),
        .clip(scal_clip)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_in;
        assign lane_in = {{(DATA_W-HALF_W){operand[g*HALF_W+HALF_W-1]}},
                          operand[g*HALF_W +: HALF_W]};
        sat_clamp #(.DW(DATA_W), .SW(SH_W)) u_half (
            .val (lane_in),
            .imm (sat_imm),
            .uns (is_unsigned),
            .res (lane_res[g]),
            .clip(lane_clip[g])
        );
        assign dual_word[g*HALF_W +: HALF_W] = lane_res[g][HALF_W-1:0];
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        stage_d.qset  = 1'b0;
        if (in_valid) begin
            stage_d.uns  = is_unsigned;
            stage_d.dual = is_dual;
            stage_d.res  = is_dual ? dual_word : scal_res;
            stage_d.qset = is_dual ? (|lane_clip) : scal_clip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.res;
    assign q_set     = stage_q.qset;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !q_set && $stable(result)));

    assert_uns_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && stage_q.uns && !stage_q.dual) |-> !result[DATA_W-1]);

    assert_flag_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_set |-> out_valid);

endmodule

// File: tb/sim_sat_shift_unit.sv
module sim_sat_shift_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  shift_amt = '0;
    logic        shift_kind = 1'b0;
    logic [4:0]  sat_imm = '0;
    logic        is_unsigned = 1'b0;
    logic        is_dual = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        q_set;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .shift_amt(shift_amt), .shift_kind(shift_kind), .sat_imm(sat_imm),
        .is_unsigned(is_unsigned), .is_dual(is_dual),
        .out_valid(out_valid), .result(result), .q_set(q_set)
    );

    function automatic longint clamp_ref(longint v, int imm, bit uns, output bit clip);
        longint lim = longint'(1) << imm;
        longint hi = lim - 1;
        longint lo = uns ? 0 : -lim;
        clip = 1'b0;
        if (v > hi) begin clip = 1'b1; return hi; end
        if (v < lo) begin clip = 1'b1; return lo; end
        return v;
    endfunction

    function automatic void model(input logic [31:0] op, input int amt, input bit kind,
                                  input int imm, input bit uns, input bit dual,
                                  output logic [31:0] res, output bit clip);
        longint v, r0, r1;
        logic [31:0] sh;
        bit c0, c1;
        if (dual) begin
            r0 = clamp_ref(longint'($signed(op[15:0])), imm, uns, c0);
            r1 = clamp_ref(longint'($signed(op[31:16])), imm, uns, c1);
            res = {r1[15:0], r0[15:0]};
            clip = c0 | c1;
        end else begin
            v = longint'($signed(op));
            if (kind) v = v >>> ((amt == 0) ? 32 : amt);
            else      v = v << amt;
            sh = v[31:0];
            r0 = clamp_ref(longint'($signed(sh)), imm, uns, c0);
            res = r0[31:0];
            clip = c0;
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] op, input int amt, input bit kind,
                          input int imm, input bit uns, input bit dual);
        logic [31:0] er;
        bit ec;
        string tag;
        model(op, amt, kind, imm, uns, dual, er, ec);
        @(negedge clk);
        in_valid = 1'b1; operand = op; shift_amt = 5'(amt); shift_kind = kind;
        sat_imm = 5'(imm); is_unsigned = uns; is_dual = dual;
        @(negedge clk);
        in_valid = 1'b0;
        if (dual)          tag = "R7";
        else if (uns)      tag = "R4";
        else if (kind)     tag = "R6";
        else if (amt != 0) tag = "R5";
        else               tag = "R3";
        check({tag, " result"}, result, er);
        check("R8 q_set", {31'b0, q_set}, {31'b0, ec});
        check("R2 out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 result in reset", result, 32'h0);
        check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 q_set after reset", {31'b0, q_set}, 32'h0);
        check("R1 result after reset", result, 32'h0);

        // R3 signed edges
        run_op(32'd200, 0, 0, 7, 0, 0);
        run_op(-32'sd200, 0, 0, 7, 0, 0);
        run_op(32'h8000_0000, 0, 0, 31, 0, 0);
        run_op(32'd1, 0, 0, 0, 0, 0);
        // R4 unsigned edges
        run_op(-32'sd5, 0, 0, 8, 1, 0);
        run_op(32'd300, 0, 0, 8, 1, 0);
        run_op(32'd1, 0, 0, 0, 1, 0);
        run_op(32'hFFFF_FFFF, 0, 0, 31, 1, 0);
        // R5 left shift
        run_op(32'd1, 31, 0, 31, 0, 0);
        run_op(32'd3, 4, 0, 31, 0, 0);
        run_op(32'h0000_0F00, 24, 0, 15, 0, 0);
        // R6 arithmetic right, zero means 32
        run_op(32'h8000_0000, 0, 1, 31, 0, 0);
        run_op(32'h7FFF_FFFF, 0, 1, 31, 0, 0);
        run_op(32'hFFFF_FF00, 4, 1, 31, 0, 0);
        // R7 dual, shift fields ignored
        run_op(32'h0100_FF00, 0, 0, 7, 0, 1);
        run_op(32'h0005_0003, 8, 0, 15, 0, 1);
        run_op(32'hFFFF_0020, 3, 1, 4, 1, 1);
        run_op(32'h7FFF_0001, 0, 0, 14, 0, 1);

        // R2 idle cycle holds result
        held = result;
        @(negedge clk);
        check("R2 idle out_valid", {31'b0, out_valid}, 32'h0);
        check("R2 idle q_set", {31'b0, q_set}, 32'h0);
        check("R2 idle result held", result, held);

        for (int i = 0; i < 3000; i++) begin
            run_op($urandom, int'($urandom_range(0, 31)), 1'($urandom),
                   int'($urandom_range(0, 31)), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule